// File: doc/BRIEF.md
# Double-Data-Rate Input Capture with Selectable Edge Alignment

This block takes a source-synchronous input that carries a new value on every clock edge and turns it into two single-rate words in the capture clock domain: a rising half, sampled on the rising edge, and a falling half, sampled on the falling edge. A 2-bit mode input selects when the falling-half sample reaches the logic downstream.

In opposite-edge mode the falling half is updated on the falling edge itself, so the logic downstream receives it half a cycle after the rising half. In same-edge mode both outputs change only on rising edges. Each rising edge pairs the new rising sample with the falling sample of the period before. In same-edge-pipelined mode the rising sample is held in one extra register, so both halves shown at a rising edge belong to the same, previous clock period. The two same-edge modes remove half-cycle paths from the logic that reads the outputs.

A capture-enable input travels alongside the data with the latency of the selected mode and appears as a valid flag. The flag marks the words that belong to an enabled read.

Top module: `ddr_input_capture`

## Requirements
- R1: In mode 2'b00 (opposite-edge) and mode 2'b01 (same-edge), the rising-half output after a rising edge equals the input value present at that rising edge.
- R2: In mode 2'b00, the falling-half output after a falling edge equals the input value present at that falling edge.
- R3: In mode 2'b01, the falling-half output after a rising edge equals the input value sampled at the falling edge of the previous clock period.
- R4: In mode 2'b10 (same-edge-pipelined), after the rising edge that ends period k, the rising-half output holds the rising sample of period k and the falling-half output holds the falling sample of period k.
- R5: In modes 2'b01 and 2'b10, neither data output changes at a falling edge.
- R6: The valid flag equals the capture-enable value sampled one rising edge earlier in modes 2'b00, 2'b01 and 2'b11, and two rising edges earlier in mode 2'b10.
- R7: A synchronous active-high reset clears both data outputs and the valid flag to zero, whatever the input and capture-enable values are.
- R8: Mode 2'b11 behaves exactly as opposite-edge mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges sample the input |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Double-data-rate input data |
| cap_en | input | 1 | Marks the current period as part of an enabled read |
| mode | input | 2 | 00 opposite-edge, 01 same-edge, 10 same-edge-pipelined, 11 as 00 |
| rise_q | output | DATA_W | Rising-half word |
| fall_q | output | DATA_W | Falling-half word |
| valid | output | 1 | Capture-enable delayed by the mode latency |

## Verification
The rising half is due one rising edge after it is sampled, or two in pipelined mode. In opposite-edge mode the falling half is due at the falling edge that samples it. In the same-edge modes it is due at the next rising edge and must then hold through the following falling edge. The driver changes the input two nanoseconds before each edge and pushes the expected word for that edge into a queue. The monitor checks one nanosecond after every edge, so each check reads exactly the register update of that edge. The expected values come from a per-period history of the driven rising sample, falling sample and enable. Modes change between periods, and each period's checks use that period's mode.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

    typedef enum logic [1:0] {
        CAP_OPPOSITE = 2'b00,
        CAP_SAME     = 2'b01,
        CAP_PIPE     = 2'b10,
        CAP_SPARE    = 2'b11
    } cap_mode_e;

    typedef struct packed {
        logic hold_rise;    // rising sample delayed one extra period
        logic fall_on_neg;  // falling half taken straight from falling-edge flop
    } align_ctl_t;

    function automatic align_ctl_t decode_mode(input logic [1:0] sel);
        align_ctl_t c;
        c.hold_rise   = (cap_mode_e'(sel) == CAP_PIPE);
        c.fall_on_neg = (cap_mode_e'(sel) == CAP_OPPOSITE) ||
                        (cap_mode_e'(sel) == CAP_SPARE);
        return c;
    endfunction

endpackage

// File: rtl/ddr_edge_sampler.sv
module ddr_edge_sampler #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rise_s,
    output logic [DATA_W-1:0] fall_s
);

    always_ff @(posedge clk) begin
        if (rst) rise_s <= '0;
        else     rise_s <= din;
    end

    always_ff @(negedge clk) begin
        if (rst) fall_s <= '0;
        else     fall_s <= din;
    end

endmodule

// File: rtl/ddr_align_stage.sv
module ddr_align_stage
    import ddr_cap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  align_ctl_t        ctl,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rise_s,
    input  logic [DATA_W-1:0] fall_s,
    input  logic              cap_en,
    output logic [DATA_W-1:0] rise_out,
    output logic [DATA_W-1:0] fall_pos,
    output logic              valid_out
);

    logic en_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_out  <= '0;
            fall_pos  <= '0;
            en_d      <= 1'b0;
            valid_out <= 1'b0;
        end else begin
            // rise_s still holds the previous period's rising sample here
            rise_out  <= ctl.hold_rise ? rise_s : din;
            fall_pos  <= fall_s;
            en_d      <= cap_en;
            valid_out <= ctl.hold_rise ? en_d : cap_en;
        end
    end

endmodule

// File: rtl/ddr_input_capture.sv
module ddr_input_capture
    import ddr_cap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              cap_en,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] rise_q,
    output logic [DATA_W-1:0] fall_q,
    output logic              valid
);

    align_ctl_t        ctl;
    logic [DATA_W-1:0] rise_s;
    logic [DATA_W-1:0] fall_s;
    logic [DATA_W-1:0] fall_pos;

    assign ctl = decode_mode(mode);

    ddr_edge_sampler #(.DATA_W(DATA_W)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .rise_s (rise_s),
        .fall_s (fall_s)
    );

    ddr_align_stage #(.DATA_W(DATA_W)) u_align (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .din       (din),
        .rise_s    (rise_s),
        .fall_s    (fall_s),
        .cap_en    (cap_en),
        .rise_out  (rise_q),
        .fall_pos  (fall_pos),
        .valid_out (valid)
    );

    assign fall_q = ctl.fall_on_neg ? fall_s : fall_pos;

endmodule

// File: rtl/ddr_input_capture_chk.sv
module ddr_input_capture_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic              cap_en,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] rise_q,
    input logic [DATA_W-1:0] fall_q,
    input logic              valid
);

    logic [DATA_W-1:0] ref_fall;

    always_ff @(negedge clk) begin
        if (rst) ref_fall <= '0;
        else     ref_fall <= din;
    end

    assert_rise_direct_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) != 2'b10) |-> rise_q == $past(din));

    assert_fall_opposite_R2: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && mode[1] == mode[0] && $past(mode) == mode)
            |-> fall_q == $past(din));

    assert_fall_same_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode == 2'b01 && $past(mode) == 2'b01)
            |-> fall_q == $past(ref_fall));

    assert_pipe_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && mode == 2'b10 && $past(mode) == 2'b10)
            |-> (rise_q == $past(din, 2) && fall_q == $past(ref_fall)));

    assert_hold_neg_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 2'b10 && mode == 2'b10)
            |-> ##1 ((mode != 2'b10) || (rise_q == $past(din, 2))));

    assert_valid_lat_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) != 2'b10) |-> valid == $past(cap_en));

    assert_valid_pipe_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(mode) == 2'b10)
            |-> valid == $past(cap_en, 2));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rise_q == '0 && !valid && (mode != 2'b01 || fall_q == '0)));

endmodule

bind ddr_input_capture ddr_input_capture_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .cap_en (cap_en),
    .mode   (mode),
    .rise_q (rise_q),
    .fall_q (fall_q),
    .valid  (valid)
);

// File: tb/ddr_input_capture_tb.sv
module ddr_input_capture_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] din;
    logic         cap_en;
    logic [1:0]   mode;
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;
    logic         valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [W-1:0] r;
        logic [W-1:0] f;
        logic         v;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    logic [W-1:0] h_r, h_f;
    logic         h_e;

    always #4 clk = ~clk;  // 125 MHz

    ddr_input_capture #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .din(din), .cap_en(cap_en), .mode(mode),
        .rise_q(rise_q), .fall_q(fall_q), .valid(valid)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (rise_q !== e.r || fall_q !== e.f || valid !== e.v) begin
            errors++;
            $display("FAIL %s: rise=%h fall=%h valid=%b expected rise=%h fall=%h valid=%b",
                     e.tag, rise_q, fall_q, valid, e.r, e.f, e.v);
        end
    endtask

    // monitor: one nanosecond after every clock edge
    initial begin
        forever begin
            @(clk);
            #1;
            if (exp_q.size() != 0) compare(exp_q.pop_front());
        end
    end

    // driver: called at 2 ns before a rising edge, returns 2 ns before the next one
    task automatic drive_period(input logic [1:0] m, input logic [W-1:0] r,
                                input logic [W-1:0] f, input logic en);
        exp_t ep, en_item;
        bit   opp;
        opp    = (m == 2'b00) || (m == 2'b11);
        mode   = m;
        din    = r;
        cap_en = en;
        ep.f   = h_f;
        if (m == 2'b10) begin
            ep.r = h_r; ep.v = h_e; ep.tag = "R4/R6";
        end else begin
            ep.r = r; ep.v = en;
            ep.tag = (m == 2'b01) ? "R3/R1/R6" : (m == 2'b11 ? "R8/R1/R6" : "R1/R6");
        end
        exp_q.push_back(ep);
        #4;
        din     = f;
        en_item = ep;
        if (opp) begin
            en_item.f   = f;
            en_item.tag = (m == 2'b11) ? "R8/R2" : "R2";
        end else begin
            en_item.tag = "R5";
        end
        exp_q.push_back(en_item);
        h_r = r; h_f = f; h_e = en;
        #4;
    endtask

    initial begin
        rst = 1'b1; din = 8'hA5; cap_en = 1'b1; mode = 2'b01;
        h_r = '0; h_f = '0; h_e = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rise_q !== '0 || fall_q !== '0 || valid !== 1'b0) begin
            errors++;
            $display("FAIL R7: rise=%h fall=%h valid=%b expected rise=00 fall=00 valid=0",
                     rise_q, fall_q, valid);
        end
        #5;  // 2 ns before a rising edge; previous falling edge saw reset
        rst = 1'b0;

        for (int i = 0; i < 10; i++)
            drive_period(2'b00, W'(i * 17 + 3), W'(8'hF0 - i), (i % 3) != 0);
        for (int i = 0; i < 10; i++)
            drive_period(2'b01, W'($urandom), W'($urandom), i[0]);
        for (int i = 0; i < 10; i++)
            drive_period(2'b10, W'($urandom), W'($urandom), (i % 4) < 2);
        for (int i = 0; i < 6; i++)
            drive_period(2'b11, W'(8'hFF), W'(8'h00), i[1]);
        for (int i = 0; i < 12; i++)
            drive_period(2'(i % 3), W'(8'h55 ^ i), W'(8'hAA ^ i), ~i[0]);
        drive_period(2'b10, 8'h00, 8'hFF, 1'b1);
        drive_period(2'b10, 8'hFF, 8'h00, 1'b0);

        // reset mid-stream with nonzero inputs
        rst = 1'b1; din = 8'h3C; cap_en = 1'b1;
        @(posedge clk); #1;
        checks++;
        if (rise_q !== '0 || valid !== 1'b0) begin
            errors++;
            $display("FAIL R7: rise=%h valid=%b expected rise=00 valid=0", rise_q, valid);
        end
        #8;  // 1 ns after the next rising edge; a falling edge saw reset
        checks++;
        if (rise_q !== '0 || fall_q !== '0 || valid !== 1'b0) begin
            errors++;
            $display("FAIL R7: rise=%h fall=%h valid=%b expected rise=00 fall=00 valid=0",
                     rise_q, fall_q, valid);
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule